// File: doc/BRIEF.md
# Frame Reference Selector with Holdover

This block sits in front of a digital phase-locked loop and decides which of two 8 kHz frame references the loop follows. It also decides when the loop must stop following any reference and coast on a remembered frequency word instead. A primary and a secondary reference are each chosen by index from a bank of candidate frame-pulse inputs. Both chosen inputs are watched at all times, the idle one as well as the one in use. A reference counts as healthy only after a run of well-timed periods. It is dropped as soon as a pulse comes too early or a pulse fails to come in time.

When the active reference fails, a per-reference policy bit says whether to move to the other reference or to freeze the loop's frequency word (holdover). When both references are down the block always goes to holdover. It returns to a locked state on its own once a usable reference is healthy again. A manual mode pins the choice to one reference. A free-running mode ignores the references and supplies a nominal word. The loop sees the result as an active-reference select, a holdover flag, a one-cycle reference-change strobe and a frequency word to use. The phase detector, filter and oscillator are outside this block. The loop appears only through the frequency word it hands in.

Top module: `refsel_holdover`

## Requirements
- R1: During and right after reset the select points at the primary (`use_sec`=0), `holdover`=1, `ref_change`=0, `freerun`=0, both health flags are 0 and `freq_out` equals NOM_WORD.
- R2: The primary and secondary are taken from any bit of `ref_in` by `pri_idx`/`sec_idx`, and a rising edge on that bit is a frame pulse. Changing an index clears the health of that channel in the next cycle.
- R3: A channel whose last pulse is more than NOM_PERIOD+TOL cycles old is not healthy. Its flag is low no later than NOM_PERIOD+TOL+3 cycles after the input edge.
- R4: A pulse interval shorter than NOM_PERIOD-TOL cycles makes the channel unhealthy. Intervals from NOM_PERIOD-TOL to NOM_PERIOD+TOL inclusive are good.
- R5: A channel turns healthy on its GOOD_N-th consecutive good interval and not before. The first pulse after reset, a failure or an index change only starts the measurement.
- R6: In automatic mode (`auto_en`=1), if the active reference fails and its policy bit (`fail_switch[0]` for primary, `fail_switch[1]` for secondary) is 1 while the other reference is healthy, the select moves to the other reference and `holdover` stays 0. With the bit at 0 the block enters holdover on the same reference.
- R7: In automatic mode, when both references are unhealthy, `holdover` is 1 in the next cycle whatever the policy bits are.
- R8: In automatic mode holdover ends when the active reference is healthy again (re-lock). Switching is non-revertive: when locked to the secondary, a recovered primary does not pull the select back.
- R9: In manual mode (`auto_en`=0), `use_sec` follows `man_sel` and `holdover` is 1 exactly when the chosen reference is unhealthy. No automatic switch takes place.
- R10: While locked, `freq_out` equals `loop_freq` one cycle later. In holdover, `freq_out` holds the `loop_freq` value seen at the second-to-last good pulse of the active reference while locked, and stays fixed whatever `loop_freq` does.
- R11: `ref_change` is a one-cycle pulse each time a lock is taken on a different reference or taken again after holdover or free-run. It never rises when holdover starts.
- R12: `mode` 2 or 3 selects free-run, giving `freerun`=1, `holdover`=0 and `freq_out`=NOM_WORD in the next cycle. Modes 0 (master) and 1 (slave) select references identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | NUM_REFS | Candidate frame-pulse inputs |
| mode | input | 2 | 0 master, 1 slave, 2/3 free-run |
| pri_idx | input | IDX_W | Index of the primary reference input |
| sec_idx | input | IDX_W | Index of the secondary reference input |
| fail_switch | input | 2 | Per-reference policy: 1 switch, 0 holdover (bit 0 primary) |
| auto_en | input | 1 | 1 automatic selection, 0 manual |
| man_sel | input | 1 | Manual choice: 0 primary, 1 secondary |
| loop_freq | input | FW | Current frequency word of the loop |
| use_sec | output | 1 | Active reference: 0 primary, 1 secondary |
| holdover | output | 1 | Loop must run from the frozen word |
| freerun | output | 1 | Free-run mode in force |
| ref_change | output | 1 | One-cycle strobe on a new or renewed lock |
| freq_out | output | FW | Frequency word for the loop to use |
| pri_ok | output | 1 | Primary reference healthy |
| sec_ok | output | 1 | Secondary reference healthy |

## Verification
The bench places pulse intervals on both edges of the acceptance window and one cycle outside it. An off-by-one comparison would either drop a good reference or keep an early one. It counts exactly how many good periods are needed before lock. A streak counter that started on the first pulse would declare health one period early. The bench freezes the loop word while the loop is still changing it and checks that the frozen value is the one from two good pulses back and does not move afterwards. A history register without the delay would freeze the word taken during the failure. The bench also brings a failed primary back while the secondary is in use, where a revertive design would switch back, and counts reference-change strobes across lock, holdover and re-lock.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    MD_MASTER  = 2'd0,
    MD_SLAVE   = 2'd1,
    MD_FREERUN = 2'd2,
    MD_FREE_X  = 2'd3
  } op_mode_e;

  localparam int NUM_CH = 2;  // channel 0 primary, channel 1 secondary

  function automatic logic mode_is_free(input logic [1:0] m);
    return (op_mode_e'(m) == MD_FREERUN) || (op_mode_e'(m) == MD_FREE_X);
  endfunction

endpackage

// File: rtl/refsel_edge_pick.sv
module refsel_edge_pick #(
  parameter int NUM_REFS = 4,
  localparam int IDX_W = $clog2(NUM_REFS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_REFS-1:0]          ref_in,
  input  logic [IDX_W-1:0]             pri_idx,
  input  logic [IDX_W-1:0]             sec_idx,
  output logic [refsel_pkg::NUM_CH-1:0] pulse_o,
  output logic [refsel_pkg::NUM_CH-1:0] clr_o
);
  import refsel_pkg::*;

  logic [NUM_REFS-1:0] sync_q, prev_q, rise;
  logic [IDX_W-1:0]    idx_in [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q <= ref_in;
      prev_q <= sync_q;
    end
  end

  assign rise      = sync_q & ~prev_q;
  assign idx_in[0] = pri_idx;
  assign idx_in[1] = sec_idx;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [IDX_W-1:0] idx_q;
    always_ff @(posedge clk) begin
      if (rst) idx_q <= '0;
      else     idx_q <= idx_in[ch];
    end
    assign pulse_o[ch] = rise[idx_in[ch]];
    assign clr_o[ch]   = (idx_q != idx_in[ch]);
  end

endmodule

// File: rtl/refsel_ref_monitor.sv
module refsel_ref_monitor #(
  parameter int NOM_PERIOD = 15625,
  parameter int TOL        = 156,
  parameter int GOOD_N     = 16,
  localparam int LO    = NOM_PERIOD - TOL,
  localparam int HI    = NOM_PERIOD + TOL,
  localparam int SAT   = HI + 1,
  localparam int CNT_W = $clog2(SAT + 1),
  localparam int STK_W = $clog2(GOOD_N + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pulse,
  output logic healthy,
  output logic good_tick
);

  logic [CNT_W-1:0] cnt;
  logic [STK_W-1:0] streak;
  logic             in_window;

  assign in_window = (cnt >= CNT_W'(LO)) && (cnt <= CNT_W'(HI));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt       <= CNT_W'(SAT);
      streak    <= '0;
      healthy   <= 1'b0;
      good_tick <= 1'b0;
    end else begin
      good_tick <= 1'b0;
      if (pulse) begin
        cnt <= CNT_W'(1);
        if (in_window) begin
          good_tick <= 1'b1;
          if (streak < STK_W'(GOOD_N)) streak <= streak + 1'b1;
          healthy <= (streak >= STK_W'(GOOD_N - 1));
        end else begin
          streak  <= '0;
          healthy <= 1'b0;
        end
      end else if (cnt >= CNT_W'(HI)) begin
        cnt     <= CNT_W'(SAT);
        streak  <= '0;
        healthy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: a pulse before the window opens leaves the channel unhealthy
  a_r4_early_reject: assert property (@(posedge clk) disable iff (rst)
    (pulse && !clr && cnt < CNT_W'(LO)) |=> !healthy);

  // R3: a saturated interval counter means the reference timed out
  a_r3_timeout_unhealthy: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(SAT)) |-> !healthy);

  // R5: health is only ever gained on a good period
  a_r5_gain_on_good: assert property (@(posedge clk) disable iff (rst)
    $rose(healthy) |-> good_tick);

endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int              FW       = 32,
  parameter logic [FW-1:0]   NOM_WORD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pri_ok,
  input  logic          sec_ok,
  input  logic          pri_good,
  input  logic          sec_good,
  input  logic [1:0]    mode,
  input  logic [1:0]    fail_switch,
  input  logic          auto_en,
  input  logic          man_sel,
  input  logic [FW-1:0] loop_freq,
  output logic          use_sec,
  output logic          holdover,
  output logic          freerun,
  output logic          ref_change,
  output logic [FW-1:0] freq_out
);
  import refsel_pkg::*;

  logic          sel_n, hold_n, frun_n, chg_n;
  logic          cur_ok, alt_ok, act_good, locked_q, locked_n;
  logic [FW-1:0] stage_q, hist_q;

  assign cur_ok   = use_sec ? sec_ok : pri_ok;
  assign alt_ok   = use_sec ? pri_ok : sec_ok;
  assign act_good = use_sec ? sec_good : pri_good;
  assign frun_n   = mode_is_free(mode);
  assign locked_q = !holdover && !freerun;

  always_comb begin
    sel_n  = use_sec;
    hold_n = holdover;
    if (frun_n) begin
      hold_n = 1'b0;
    end else if (!auto_en) begin
      sel_n  = man_sel;
      hold_n = man_sel ? !sec_ok : !pri_ok;
    end else if (cur_ok) begin
      hold_n = 1'b0;
    end else if (fail_switch[use_sec] && alt_ok) begin
      sel_n  = !use_sec;
      hold_n = 1'b0;
    end else begin
      hold_n = 1'b1;
    end
  end

  assign locked_n = !hold_n && !frun_n;
  assign chg_n    = locked_n && (!locked_q || (sel_n != use_sec));

  always_ff @(posedge clk) begin
    if (rst) begin
      use_sec    <= 1'b0;
      holdover   <= 1'b1;
      freerun    <= 1'b0;
      ref_change <= 1'b0;
      freq_out   <= NOM_WORD;
      stage_q    <= NOM_WORD;
      hist_q     <= NOM_WORD;
    end else begin
      use_sec    <= sel_n;
      holdover   <= hold_n;
      freerun    <= frun_n;
      ref_change <= chg_n;
      if (frun_n)      freq_out <= NOM_WORD;
      else if (hold_n) freq_out <= hist_q;
      else             freq_out <= loop_freq;
      if (locked_q && act_good && cur_ok) begin
        stage_q <= loop_freq;
        hist_q  <= stage_q;
      end
    end
  end

  // R7: both references down in automatic mode forces holdover
  a_r7_both_down_hold: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !frun_n && !pri_ok && !sec_ok) |=> holdover);

  // R10: the frozen word never moves while holdover is in force
  a_r10_frozen_word: assert property (@(posedge clk) disable iff (rst)
    holdover |=> $stable(hist_q));

  // R12: free-run selection takes effect one cycle later
  a_r12_freerun_out: assert property (@(posedge clk) disable iff (rst)
    frun_n |=> (freerun && !holdover && freq_out == NOM_WORD));

endmodule

// File: rtl/refsel_holdover.sv
module refsel_holdover #(
  parameter int            NUM_REFS   = 4,
  parameter int            NOM_PERIOD = 15625,
  parameter int            TOL        = 156,
  parameter int            GOOD_N     = 16,
  parameter int            FW         = 32,
  parameter logic [FW-1:0] NOM_WORD   = FW'(1) << (FW - 1),
  localparam int IDX_W = $clog2(NUM_REFS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REFS-1:0] ref_in,
  input  logic [1:0]          mode,
  input  logic [IDX_W-1:0]    pri_idx,
  input  logic [IDX_W-1:0]    sec_idx,
  input  logic [1:0]          fail_switch,
  input  logic                auto_en,
  input  logic                man_sel,
  input  logic [FW-1:0]       loop_freq,
  output logic                use_sec,
  output logic                holdover,
  output logic                freerun,
  output logic                ref_change,
  output logic [FW-1:0]       freq_out,
  output logic                pri_ok,
  output logic                sec_ok
);
  import refsel_pkg::*;

  logic [NUM_CH-1:0] ch_pulse, ch_clr, ch_ok, ch_tick;

  refsel_edge_pick #(.NUM_REFS(NUM_REFS)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .ref_in  (ref_in),
    .pri_idx (pri_idx),
    .sec_idx (sec_idx),
    .pulse_o (ch_pulse),
    .clr_o   (ch_clr)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mon
    refsel_ref_monitor #(
      .NOM_PERIOD (NOM_PERIOD),
      .TOL        (TOL),
      .GOOD_N     (GOOD_N)
    ) u_mon (
      .clk       (clk),
      .rst       (rst),
      .clr       (ch_clr[ch]),
      .pulse     (ch_pulse[ch]),
      .healthy   (ch_ok[ch]),
      .good_tick (ch_tick[ch])
    );
  end

  refsel_ctrl #(.FW(FW), .NOM_WORD(NOM_WORD)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .pri_ok      (ch_ok[0]),
    .sec_ok      (ch_ok[1]),
    .pri_good    (ch_tick[0]),
    .sec_good    (ch_tick[1]),
    .mode        (mode),
    .fail_switch (fail_switch),
    .auto_en     (auto_en),
    .man_sel     (man_sel),
    .loop_freq   (loop_freq),
    .use_sec     (use_sec),
    .holdover    (holdover),
    .freerun     (freerun),
    .ref_change  (ref_change),
    .freq_out    (freq_out)
  );

  assign pri_ok = ch_ok[0];
  assign sec_ok = ch_ok[1];

  // R11: the change strobe only accompanies a locked state
  a_r11_strobe_locked: assert property (@(posedge clk) disable iff (rst)
    ref_change |-> (!holdover && !freerun));

endmodule

// File: tb/refsel_holdover_test.sv
`timescale 1ns/1ps
module refsel_holdover_test;
  localparam int            NREF = 4;
  localparam int            NOM  = 40;
  localparam int            TOL  = 3;
  localparam int            GN   = 3;
  localparam int            FW   = 16;
  localparam logic [15:0]   NOMW = 16'h8000;

  // row: {auto, fail_switch[1:0], man_sel, pri_alive, sec_alive, exp_sel, exp_hold}
  localparam logic [7:0] TBL [0:7] = '{
    8'b1110_0110,  // R6 switch to secondary
    8'b1000_0101,  // R6 policy 0 -> holdover
    8'b1110_0001,  // R7 both dead -> holdover
    8'b1000_1100,  // both alive, stay on primary
    8'b0001_1110,  // R9 manual secondary
    8'b0001_1011,  // R9 manual secondary unhealthy
    8'b0110_0101,  // R9 manual: no automatic switch
    8'b1100_0101   // R6 only primary bit counts for primary
  };

  logic            clk = 1'b0;
  logic            rst;
  logic [NREF-1:0] ref_in;
  logic [1:0]      mode, pri_idx, sec_idx, fail_switch;
  logic            auto_en, man_sel;
  logic [FW-1:0]   loop_freq;
  logic            use_sec, holdover, freerun, ref_change, pri_ok, sec_ok;
  logic [FW-1:0]   freq_out;
  int              n_chk = 0, n_fail = 0, chg_cnt = 0;

  always #4 clk = ~clk;

  refsel_holdover #(.NUM_REFS(NREF), .NOM_PERIOD(NOM), .TOL(TOL), .GOOD_N(GN),
                    .FW(FW), .NOM_WORD(NOMW)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .mode(mode), .pri_idx(pri_idx),
    .sec_idx(sec_idx), .fail_switch(fail_switch), .auto_en(auto_en),
    .man_sel(man_sel), .loop_freq(loop_freq), .use_sec(use_sec),
    .holdover(holdover), .freerun(freerun), .ref_change(ref_change),
    .freq_out(freq_out), .pri_ok(pri_ok), .sec_ok(sec_ok));

  always @(negedge clk) if (!rst && ref_change) chg_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ref_in = '0; mode = 2'd0; pri_idx = 2'd1; sec_idx = 2'd2;
    fail_switch = 2'b00; auto_en = 1'b1; man_sel = 1'b0; loop_freq = 16'h1234;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // n pulses on the masked inputs, d cycles apart
  task automatic run(input logic [NREF-1:0] m, input int d, input int n);
    for (int i = 0; i < n; i++) begin
      ref_in = m;
      @(negedge clk);
      ref_in = '0;
      repeat (d - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 use_sec", use_sec, 0);
    chk("R1 holdover", holdover, 1);
    chk("R1 ref_change", ref_change, 0);
    chk("R1 freerun", freerun, 0);
    chk("R1 health", {pri_ok, sec_ok}, 0);
    chk("R1 freq_out", freq_out, NOMW);

    // table of selection scenarios (R6 R7 R9)
    for (int r = 0; r < 8; r++) begin
      do_reset();
      auto_en = TBL[r][7]; fail_switch = TBL[r][6:5]; man_sel = TBL[r][4];
      run(4'b0110, NOM, 6);
      run({1'b0, TBL[r][2], TBL[r][3], 1'b0}, NOM, 4);
      chk($sformatf("R6/R7/R9 row%0d use_sec", r), use_sec, TBL[r][1]);
      chk($sformatf("R6/R7/R9 row%0d holdover", r), holdover, TBL[r][0]);
    end

    // R5 lock count, R11 strobe
    do_reset();
    chg_cnt = 0;
    run(4'b0010, NOM, 3);
    chk("R5 not yet healthy", pri_ok, 0);
    run(4'b0010, NOM, 1);
    chk("R5 healthy on GOOD_N", pri_ok, 1);
    chk("R11 one strobe on lock", chg_cnt, 1);
    // R4 window edges: intervals HI and LO are good
    run(4'b0010, NOM + TOL, 1);
    run(4'b0010, NOM - TOL, 1);
    run(4'b0010, NOM, 1);
    chk("R4 edges good", pri_ok, 1);
    run(4'b0010, NOM - TOL - 1, 1);
    run(4'b0010, NOM, 1);
    chk("R4 early pulse", pri_ok, 0);
    chk("R6 policy0 holdover", holdover, 1);
    chk("R11 no strobe on holdover", chg_cnt, 1);
    // R8 re-lock
    run(4'b0010, NOM, 4);
    chk("R8 relock", holdover, 0);
    chk("R11 strobe on relock", chg_cnt, 2);
    // R3 timeout
    repeat (6) @(negedge clk);
    chk("R3 timeout", pri_ok, 0);

    // R10 holdover word
    do_reset();
    for (int k = 0; k < 8; k++) begin
      loop_freq = 16'h1000 + 16'(k);
      run(4'b0010, NOM, 1);
    end
    loop_freq = 16'h2222;
    repeat (2) @(negedge clk);
    chk("R10 pass-through", freq_out, 16'h2222);
    loop_freq = 16'hDEAD;
    repeat (60) @(negedge clk);
    chk("R10 in holdover", holdover, 1);
    chk("R10 frozen word", freq_out, 16'h1006);
    loop_freq = 16'hBEEF;
    repeat (5) @(negedge clk);
    chk("R10 word stays", freq_out, 16'h1006);

    // R12 free-run
    mode = 2'd2;
    repeat (2) @(negedge clk);
    chk("R12 freerun flag", freerun, 1);
    chk("R12 no holdover", holdover, 0);
    chk("R12 nominal word", freq_out, NOMW);
    mode = 2'd1;
    repeat (2) @(negedge clk);
    chk("R12 slave mode", freerun, 0);

    // R2 index selection and index change
    do_reset();
    pri_idx = 2'd3;
    run(4'b1000, NOM, 4);
    chk("R2 any index", pri_ok, 1);
    pri_idx = 2'd0;
    repeat (3) @(negedge clk);
    chk("R2 index change clears", pri_ok, 0);

    // R8 non-revertive
    do_reset();
    fail_switch = 2'b01;
    run(4'b0110, NOM, 6);
    run(4'b0100, NOM, 3);
    chk("R8 switched", use_sec, 1);
    run(4'b0110, NOM, 6);
    chk("R8 stays on secondary", use_sec, 1);
    chk("R8 locked", holdover, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule